// File: doc/BRIEF.md
# Program Status and Banked Saved-Status Unit

This block holds the live program status word of a processor core and a bank of saved status words, one for each exception mode. The live word carries the five condition flags (negative, zero, carry, overflow, saturation), two interrupt mask bits, the instruction-set state bit and the five-bit mode field. The block drives these fields to the rest of the core as separate outputs and reports whether the core is in a privileged mode.

A write port replaces the live word. A second port reads and writes the saved word, and the live mode field picks which of the five saved registers that port reaches. A restore strobe copies the selected saved word into the live word on the next clock edge, as an exception return does. The copied word can carry a different mode, so after a restore the saved port can point at a different register. Fixed bit positions: flags N, Z, C, V, Q at bits 31 to 27, IRQ mask at 7, FIQ mask at 6, T at 5 and mode at 4:0. Mode codes: user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F.

Top module: `stat_unit`

## Requirements
- R1: While reset is held and after it is released, the live word reads 0x00000010: user mode, both masks clear, T clear, all flags clear. Every saved register reads as zero.
- R2: A live-word write with no restore in the same cycle stores the written value ANDed with 0xF80000FF. The result appears on the live read port after the next rising edge. All other bits read as zero.
- R3: The flag outputs show bits 31:27 as {N,Z,C,V,Q}. The IRQ mask output shows bit 7, the FIQ mask output shows bit 6, the T output shows bit 5, and the mode output shows bits 4:0 of the live word.
- R4: In each of the five exception modes (0x11, 0x12, 0x13, 0x17, 0x1B), the saved port reads and writes a register of its own. A saved write stores the value ANDed with 0xF80000FF and leaves the other four registers unchanged.
- R5: In user mode, system mode or any mode code not listed, the saved port reads zero and a saved write changes no register.
- R6: In an exception mode, a restore loads the selected saved word into the live word at the next edge. After that edge the saved port follows the mode of the restored word.
- R7: In user mode, system mode or an unlisted mode code, a restore leaves the live word unchanged.
- R8: The privileged output is high for modes 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F. It is low for 0x10 and for unlisted codes.
- R9: A restore takes priority over a live write in the same cycle. A saved write in the same cycle as a restore updates the selected register, but the restore copies the value that register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_we | input | 1 | Live-word write enable |
| cur_wdata | input | 32 | Live-word write value |
| cur_rdata | output | 32 | Live-word read value |
| sav_we | input | 1 | Saved-word write enable (mode-selected) |
| sav_wdata | input | 32 | Saved-word write value |
| sav_rdata | output | 32 | Saved-word read value (mode-selected) |
| restore | input | 1 | Copy selected saved word into live word |
| mode_o | output | 5 | Live mode field |
| irq_mask_o | output | 1 | IRQ mask bit |
| fiq_mask_o | output | 1 | FIQ mask bit |
| thumb_o | output | 1 | Instruction-set state bit |
| flags_o | output | 5 | {N,Z,C,V,Q} |
| priv_o | output | 1 | Privileged-mode indicator |

## Verification
The bench builds the block with its default values: a 32-bit word and five saved registers. With these values every mode code fits in the five-bit field, so the bench can step through all five banks, the user and system modes and an unlisted code. It covers restores that move to another exception mode and restores that drop back to user mode. It also drives the same-cycle collisions of restore, live write and saved write, where the old-mode selection decides the result.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int WORD_W  = 32;
    localparam int NBANK   = 5;
    localparam int BIDX_W  = $clog2(NBANK);
    localparam int MODE_W  = 5;
    localparam int FLAG_W  = 5;

    localparam int FLAG_HI = 31;
    localparam int IRQ_BIT = 7;
    localparam int FIQ_BIT = 6;
    localparam int T_BIT   = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    localparam logic [WORD_W-1:0] KEEP_MASK = 32'hF800_00FF;
    localparam logic [WORD_W-1:0] RESET_WORD = {{(WORD_W-MODE_W){1'b0}}, MODE_USR};

    typedef struct packed {
        logic              bank_ok;
        logic [BIDX_W-1:0] bank_idx;
        logic              priv;
    } mode_info_t;

    typedef struct packed {
        logic [WORD_W-1:0] psr;
    } live_state_t;

endpackage

// File: rtl/stat_mode_decode.sv
module stat_mode_decode
    import stat_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output mode_info_t        info_o
);

    always_comb begin
        info_o = '{bank_ok: 1'b0, bank_idx: '0, priv: 1'b0};
        unique case (mode_i)
            MODE_FIQ: info_o = '{bank_ok: 1'b1, bank_idx: BIDX_W'(0), priv: 1'b1};
            MODE_IRQ: info_o = '{bank_ok: 1'b1, bank_idx: BIDX_W'(1), priv: 1'b1};
            MODE_SVC: info_o = '{bank_ok: 1'b1, bank_idx: BIDX_W'(2), priv: 1'b1};
            MODE_ABT: info_o = '{bank_ok: 1'b1, bank_idx: BIDX_W'(3), priv: 1'b1};
            MODE_UND: info_o = '{bank_ok: 1'b1, bank_idx: BIDX_W'(4), priv: 1'b1};
            MODE_SYS: info_o = '{bank_ok: 1'b0, bank_idx: '0, priv: 1'b1};
            default:  info_o = '{bank_ok: 1'b0, bank_idx: '0, priv: 1'b0};
        endcase
    end

endmodule

// File: rtl/stat_saved_bank.sv
module stat_saved_bank
    import stat_pkg::*;
#(
    parameter int N_ENT = NBANK,
    parameter int W     = WORD_W,
    localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_ok_i,
    input  logic [IW-1:0] sel_idx_i,
    input  logic          we_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o
);

    logic [N_ENT-1:0][W-1:0] bank_d, bank_q;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_comb begin
            bank_d[g] = bank_q[g];
            if (we_i && sel_ok_i && (sel_idx_i == IW'(g))) begin
                bank_d[g] = wdata_i & KEEP_MASK[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (sel_ok_i && (sel_idx_i == IW'(i))) begin
                rdata_o = bank_q[i];
            end
        end
    end

    // R5: with no bank selected the read port is held at zero
    assert_unsel_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok_i |-> (rdata_o == '0));

    // R4: a selected write is visible on the same selection one cycle later
    assert_bank_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_ok_i) ##1 (sel_ok_i && $stable(sel_idx_i))
        |-> (rdata_o == ($past(wdata_i) & KEEP_MASK[W-1:0])));

endmodule

// File: rtl/stat_unit.sv
module stat_unit
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_we,
    input  logic [WORD_W-1:0] cur_wdata,
    output logic [WORD_W-1:0] cur_rdata,
    input  logic              sav_we,
    input  logic [WORD_W-1:0] sav_wdata,
    output logic [WORD_W-1:0] sav_rdata,
    input  logic              restore,
    output logic [MODE_W-1:0] mode_o,
    output logic              irq_mask_o,
    output logic              fiq_mask_o,
    output logic              thumb_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              priv_o
);

    live_state_t st_d, st_q;
    mode_info_t  info;
    logic [WORD_W-1:0] sel_word;

    stat_mode_decode u_dec (
        .mode_i (st_q.psr[MODE_W-1:0]),
        .info_o (info)
    );

    stat_saved_bank #(
        .N_ENT (NBANK),
        .W     (WORD_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_ok_i  (info.bank_ok),
        .sel_idx_i (info.bank_idx),
        .we_i      (sav_we),
        .wdata_i   (sav_wdata),
        .rdata_o   (sel_word)
    );

    always_comb begin
        st_d = st_q;
        if (restore && info.bank_ok) begin
            st_d.psr = sel_word & KEEP_MASK;
        end else if (cur_we) begin
            st_d.psr = cur_wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{psr: RESET_WORD};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_rdata  = st_q.psr;
    assign sav_rdata  = sel_word;
    assign mode_o     = st_q.psr[MODE_W-1:0];
    assign irq_mask_o = st_q.psr[IRQ_BIT];
    assign fiq_mask_o = st_q.psr[FIQ_BIT];
    assign thumb_o    = st_q.psr[T_BIT];
    assign flags_o    = st_q.psr[FLAG_HI -: FLAG_W];
    assign priv_o     = info.priv;

    assert_live_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_we && !restore) |=> (cur_rdata == ($past(cur_wdata) & KEEP_MASK)));

    assert_restore_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && (priv_o && mode_o != MODE_SYS)) |=> (cur_rdata == $past(sav_rdata)));

    assert_restore_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !cur_we && (mode_o == MODE_USR || mode_o == MODE_SYS)) |=> $stable(cur_rdata));

    assert_user_unpriv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_USR) |-> !priv_o);

endmodule

// File: tb/sim_stat_unit.sv
module sim_stat_unit;
    import stat_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cur_we = 1'b0, sav_we = 1'b0, restore = 1'b0;
    logic [31:0] cur_wdata = '0, sav_wdata = '0;
    logic [31:0] cur_rdata, sav_rdata;
    logic [4:0]  mode_o, flags_o;
    logic irq_mask_o, fiq_mask_o, thumb_o, priv_o;

    always #4 clk = ~clk;

    stat_unit u0 (.*);

    typedef struct {
        logic [31:0] cur;
        logic [31:0] sav;
        logic        priv;
        string       req;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_cur;
    logic [31:0] m_sav [5];

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            5'h1B: return 4;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic cwe, input logic [31:0] cwd, input logic swe,
                        input logic [31:0] swd, input logic rs, input string req);
        exp_t e;
        int idx;
        int nidx;
        logic [31:0] old_sav;
        @(negedge clk);
        cur_we = cwe; cur_wdata = cwd; sav_we = swe; sav_wdata = swd; restore = rs;
        idx = bank_of(m_cur[4:0]);
        old_sav = (idx >= 0) ? m_sav[idx] : 32'h0;
        if (swe && idx >= 0) m_sav[idx] = swd & 32'hF800_00FF;
        if (rs && idx >= 0) m_cur = old_sav;
        else if (cwe) m_cur = cwd & 32'hF800_00FF;
        nidx = bank_of(m_cur[4:0]);
        e.cur = m_cur;
        e.sav = (nidx >= 0) ? m_sav[nidx] : 32'h0;
        e.priv = (nidx >= 0) || (m_cur[4:0] == 5'h1F);
        e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        step(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, req);
    endtask

    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.req, " live"}, cur_rdata, e.cur);
            check({e.req, " saved"}, sav_rdata, e.sav);
            check({e.req, " priv R8"}, {31'h0, priv_o}, {31'h0, e.priv});
            check("R3 fields", {flags_o, irq_mask_o, fiq_mask_o, thumb_o, mode_o},
                  {e.cur[31:27], e.cur[7], e.cur[6], e.cur[5], e.cur[4:0]});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_cur = 32'h10;
        for (int i = 0; i < 5; i++) m_sav[i] = 32'h0;
        repeat (3) @(negedge clk);
        check("R1 live in reset", cur_rdata, 32'h10);
        check("R1 saved in reset", sav_rdata, 32'h0);
        rst_n = 1'b1;
        idle("R1 after reset");
        // R2: all bits written, only kept ones stored; system mode
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, "R2 all ones");
        // R5: system mode saved write ignored, read zero
        step(1'b0, 0, 1'b1, 32'hDEAD_BEEF, 1'b0, "R5 sys write");
        // R7: restore in system mode
        step(1'b0, 0, 1'b0, 0, 1'b1, "R7 sys restore");
        // R2/R3 fast interrupt mode with flags
        step(1'b1, 32'h5123_45D1, 1'b0, 0, 1'b0, "R2 fiq entry");
        // R4: write each bank with its own value
        for (int i = 0; i < 5; i++) begin
            logic [4:0] mc;
            mc = (i == 0) ? 5'h11 : (i == 1) ? 5'h12 : (i == 2) ? 5'h13 : (i == 3) ? 5'h17 : 5'h1B;
            step(1'b1, {27'h0, mc}, 1'b0, 0, 1'b0, "R4 enter mode");
            step(1'b0, 0, 1'b1, 32'h1111_1100 * (i + 1) | 32'h0000_00E0 | 32'(i), 1'b0, "R4 saved write");
        end
        for (int i = 0; i < 5; i++) begin
            logic [4:0] mc;
            mc = (i == 0) ? 5'h11 : (i == 1) ? 5'h12 : (i == 2) ? 5'h13 : (i == 3) ? 5'h17 : 5'h1B;
            step(1'b1, {27'h0, mc}, 1'b0, 0, 1'b0, "R4 bank readback");
        end
        // R5: user mode and unlisted code, saved writes ignored
        step(1'b1, 32'h0000_0010, 1'b0, 0, 1'b0, "R8 user");
        step(1'b0, 0, 1'b1, 32'hFFFF_FFFF, 1'b0, "R5 user write");
        step(1'b0, 0, 1'b0, 0, 1'b1, "R7 user restore");
        step(1'b1, 32'h0000_0015, 1'b0, 0, 1'b0, "R8 unlisted");
        step(1'b0, 0, 1'b1, 32'hFFFF_FFFF, 1'b0, "R5 unlisted write");
        step(1'b0, 0, 1'b0, 0, 1'b1, "R7 unlisted restore");
        step(1'b1, 32'h0000_0011, 1'b0, 0, 1'b0, "R5 fiq bank untouched");
        // R6: supervisor saved word holds user mode
        step(1'b1, 32'h0000_0013, 1'b0, 0, 1'b0, "R6 enter svc");
        step(1'b0, 0, 1'b1, 32'h6000_00D0, 1'b0, "R6 svc saved");
        step(1'b0, 0, 1'b0, 0, 1'b1, "R6 restore to user");
        // R6: abort saved word holds irq mode; saved port follows new mode
        step(1'b1, 32'h0000_0017, 1'b0, 0, 1'b0, "R6 enter abt");
        step(1'b0, 0, 1'b1, 32'h8000_0092, 1'b0, "R6 abt saved");
        step(1'b0, 0, 1'b0, 0, 1'b1, "R6 restore to irq");
        // R9: collisions in undefined mode
        step(1'b1, 32'h0000_001B, 1'b0, 0, 1'b0, "R9 enter und");
        step(1'b0, 0, 1'b1, 32'h2000_0013, 1'b0, "R9 und saved");
        step(1'b1, 32'hF000_0010, 1'b1, 32'h0800_0011, 1'b1, "R9 collide");
        step(1'b1, 32'h0000_001B, 1'b0, 0, 1'b0, "R9 und bank updated");
        idle("R9 settle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule